// File: doc/BRIEF.md
# Self-Correcting One-Hot Ring Counter

This block is a one-hot sequencer. A left-shifting register moves a single 1 from the least significant bit toward the most significant bit on every clock. A plain ring would feed the top bit straight back into the bottom. Here, the bit entering the bottom comes from a small correction term: it is 1 only when every bit below the top one is 0. Because of that term, a state with no 1 at all, or with more than one 1, cannot keep circulating. Every such state drains into the normal one-hot cycle within a bounded number of clocks.

The counter suits sequencing or phase selection where a noise event must not leave the machine stuck. The width is a parameter, with a default of 4. A synchronous, active-low reset loads the single 1 into bit 0. The parallel state is the only output.

Top module: `selfcorr_ring`

## Requirements
- R1: While rst_n is low at a rising clock edge, the state becomes 0...01 (only bit 0 set). Reset is synchronous and takes priority over shifting.
- R2: With rst_n high, each rising edge moves every state bit k to bit k+1, for k from 0 to WIDTH-2. The old top bit is discarded.
- R3: With rst_n high, the new bit 0 is 1 exactly when bits WIDTH-2 down to 0 of the current state are all 0, and is 0 otherwise.
- R4: Starting from 0...01, the state visits 0001, 0010, 0100, 1000 and then 0001 again (for WIDTH=4), repeating with a period of WIDTH clocks.
- R5: The all-zero state is left on the very next edge and becomes 0...01.
- R6: From any of the 2^WIDTH states, the state is one-hot within WIDTH-1 clock edges. It equals 0...01 within WIDTH edges.
- R7: Once the state is one-hot, it stays one-hot on every later edge while rst_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low; loads 0...01 |
| state_o | output | WIDTH | Current counter state, bit 0 is the entry position |

## Verification
The bench forces each of the sixteen 4-bit states into the register in turn and then runs the counter freely. The seeds fall into three groups, and each group separates a different fault:
- The empty state 0000 shows whether the correction term injects a 1 at all.
- Multi-one seeds such as 0101 and 1111 show whether extra ones are flushed out or keep circulating.
- The four one-hot seeds show that the normal cycle is untouched and keeps a period of four.

A reset applied mid-cycle checks that reset takes priority over shifting.

// File: rtl/ringctr_pkg.sv
// Package: shared constants for the self-correcting ring counter.
// Assumes: consumers use MIN_WIDTH to guard their WIDTH parameter.
package ringctr_pkg;
    // Smallest width for which a correction window (bits WIDTH-2..0) exists.
    localparam int MIN_WIDTH = 2;
endpackage

// File: rtl/ring_fix_term.sv
// Module: ring_fix_term
// Computes the serial entry bit. It is 1 only when all bits below the top
// bit are clear, which lets a lone 1 re-enter after it leaves the top and
// blocks any 1 from entering while other ones are still present.
// Assumes: WIDTH >= 2.
module ring_fix_term #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic             entry_o
);
    localparam int LOW_W = WIDTH - 1;

    logic [LOW_W-1:0] any_hi;

    // Builds a running OR over the low window, one stage per bit.
    genvar g;
    generate
        for (g = 0; g < LOW_W; g++) begin : g_or
            if (g == 0) begin : g_first
                assign any_hi[g] = cur_i[g];
            end else begin : g_next
                assign any_hi[g] = any_hi[g-1] | cur_i[g];
            end
        end
    endgenerate

    // Entry bit is the NOR of the low window.
    always_comb entry_o = ~any_hi[LOW_W-1];
endmodule

// File: rtl/ring_shift_reg.sv
// Module: ring_shift_reg
// State register: loads 0...01 on synchronous reset; otherwise shifts up by
// one place and takes entry_i into bit 0.
// Assumes: rst_n is synchronous to clk.
module ring_shift_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_i,
    output logic [WIDTH-1:0] state_q
);
    localparam logic [WIDTH-1:0] HOME = {{(WIDTH-1){1'b0}}, 1'b1};

    // Holds the counter state; reset wins over shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HOME;
        end else begin
            state_q <= {state_q[WIDTH-2:0], entry_i};
        end
    end
endmodule

// File: rtl/selfcorr_ring.sv
// Module: selfcorr_ring (top)
// One-hot ring counter that recovers from any corrupted state. The shift
// register's entry bit comes from ring_fix_term instead of a plain
// top-bit feedback.
// Assumes: WIDTH >= ringctr_pkg::MIN_WIDTH; clock and reset are synchronous.
module selfcorr_ring #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] state_o
);
    import ringctr_pkg::*;

    logic [WIDTH-1:0] cur;
    logic             entry;

    // Elaboration guard on the width parameter.
    generate
        if (WIDTH < MIN_WIDTH) begin : g_bad_width
            initial $error("selfcorr_ring: WIDTH must be at least %0d", MIN_WIDTH);
        end
    endgenerate

    ring_fix_term #(.WIDTH(WIDTH)) u_fix (
        .cur_i   (cur),
        .entry_o (entry)
    );

    ring_shift_reg #(.WIDTH(WIDTH)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .entry_i (entry),
        .state_q (cur)
    );

    // Drives the parallel output from the register.
    always_comb state_o = cur;
endmodule

// File: rtl/selfcorr_ring_chk.sv
// Module: selfcorr_ring_chk
// Checker bound to selfcorr_ring; watches the state output over time.
// Assumes: WIDTH >= 2.
module selfcorr_ring_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] state
);
    localparam logic [WIDTH-1:0] HOME = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam int CW = $clog2(WIDTH + 1) + 1;

    logic [CW-1:0] bad_run;

    // Counts consecutive sampled edges on which the state was not one-hot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_run <= '0;
        end else if ($countones(state) != 1) begin
            if (bad_run != {CW{1'b1}}) bad_run <= bad_run + 1'b1;
        end else begin
            bad_run <= '0;
        end
    end

    // R1
    reset_home_chk: assert property (@(posedge clk)
        !rst_n ##1 !rst_n |-> state == HOME);

    // R2
    shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> state[WIDTH-1:1] == $past(state[WIDTH-2:0]));

    // R3
    entry_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> state[0] == ($past(state[WIDTH-2:0]) == '0));

    // R5
    empty_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == '0 |=> state == HOME);

    // R6
    recover_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_run < CW'(WIDTH));

    // R7
    onehot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state) == 1 |=> $countones(state) == 1);
endmodule

bind selfcorr_ring selfcorr_ring_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state_o)
);

// File: tb/selfcorr_ring_test.sv
module selfcorr_ring_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] state_o;
    logic [W-1:0] seed_v;

    int errors = 0;
    int checks = 0;
    int model;
    bit done = 1'b0;

    selfcorr_ring #(.WIDTH(W)) uut (.clk(clk), .rst_n(rst_n), .state_o(state_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural next state, written from R2/R3: shift up, enter 1 if low window empty.
    function automatic int ref_next(int s);
        int low;
        low = s % (1 << (W-1));
        return ((s * 2) % (1 << W)) + ((low == 0) ? 1 : 0);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Runs one edge and compares against the model at the following falling edge.
    task automatic step_cmp();
        @(posedge clk);
        model = ref_next(model);
        @(negedge clk);
        check("R2 R3 model", int'(state_o), model);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int reach;
        // R1: reset state
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset", int'(state_o), 1);
        rst_n = 1'b1;
        model = 1;
        // R4: normal cycle from home, period W
        for (int c = 0; c < 2*W; c++) begin
            step_cmp();
            check("R4 cycle", int'(state_o), 1 << ((c + 1) % W));
        end
        // R1: mid-run reset priority
        step_cmp();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run reset", int'(state_o), 1);
        // R5/R6/R7: seed every state
        for (int s = 0; s < (1 << W); s++) begin
            rst_n = 1'b0;
            @(posedge clk);
            @(negedge clk);
            seed_v = W'(s);
            force uut.u_shift.state_q = seed_v;
            #1;
            release uut.u_shift.state_q;
            rst_n = 1'b1;
            check("R6 seed", int'(state_o), s);
            model = s;
            reach = -1;
            for (int c = 1; c <= W; c++) begin
                step_cmp();
                if (s == 0 && c == 1) check("R5 empty exit", int'(state_o), 1);
                if (reach < 0 && state_o == W'(1)) reach = c;
            end
            check("R6 reaches home within W", (reach > 0) ? 1 : 0, 1);
            // R7 and R4: stays one-hot and repeats with period W
            for (int c = 0; c < W; c++) begin
                step_cmp();
                check("R7 one-hot", $countones(state_o), 1);
            end
            check("R4 period", int'(state_o), model);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule